// File: doc/BRIEF.md
# Command Packet Framer

This block sits behind the receiver of a narrow command bus. Each cycle it samples a 10-bit command/address lane and a start flag. A packet is four consecutive words, and the flag is high only on the first of them. Once the fourth word has been captured, the block presents the whole 40-bit packet. Alongside it come the packet's fields, already split out: device ID, command code, bank, row and column. A valid strobe lasting one cycle marks the new packet.

The fields are spread across word boundaries in a fixed bit order, and the decoder undoes that order. If the flag rises again before a packet is complete, the partial packet is thrown away and collection restarts from the current word. Spare bit positions should carry zeros. If they do not, the packet is still delivered, and a format-error strobe is raised together with its valid strobe. Words that arrive while the block is idle with the flag low are ignored.

Top module: `cmd_framer`

## Requirements
- R1: While rst_ni is low, and after it is released, pkt_valid_o and fmt_err_o are 0 and pkt_o is all zeros. The block is then idle, waiting for the flag.
- R2: A packet consists of four words. The flag is 1 on word 1 and 0 on words 2 to 4. pkt_valid_o pulses in the cycle after the edge that samples word 4. pkt_o then holds word 1 in bits 39:30, word 2 in bits 29:20, word 3 in bits 19:10 and word 4 in bits 9:0.
- R3: dev_id_o is word 1 bits 9:1, which is pkt_o[39:31].
- R4: cmd_o is 6 bits. Its bit 5 is word 1 bit 0, and its bits 4:0 are word 2 bits 9:5.
- R5: bank_o is word 2 bits 4:2.
- R6: row_o is 11 bits. Its bits 10:9 are word 2 bits 1:0, and its bits 8:0 are word 3 bits 9:1.
- R7: col_o is word 4 bits 6:0.
- R8: While idle, words sampled with the flag low have no effect: no strobe appears and pkt_o keeps its value.
- R9: A flag seen high while a packet is being collected, on word position 2, 3 or 4, discards the partial packet. The current word becomes word 1 of a new packet, and no strobe is produced for the discarded words.
- R10: The spare bits are word 3 bit 0 and word 4 bits 9:7. fmt_err_o is 1 in the strobe cycle exactly when any spare bit is 1, and 0 at all other times. The packet is delivered either way.
- R11: pkt_valid_o lasts exactly one cycle. pkt_o and the decoded fields hold their values until the next packet completes.
- R12: A new packet may start with its flag on the cycle directly after word 4, so packets can arrive back to back every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flag_i | input | 1 | Start-of-packet flag |
| ca_i | input | 10 | Command/address lane |
| pkt_valid_o | output | 1 | One-cycle strobe for a completed packet |
| pkt_o | output | 40 | Assembled packet, word 1 in the MSBs |
| dev_id_o | output | 9 | Device ID field |
| cmd_o | output | 6 | Command code field |
| bank_o | output | 3 | Bank field |
| row_o | output | 11 | Row field |
| col_o | output | 7 | Column field |
| fmt_err_o | output | 1 | Spare bits nonzero, given with the strobe |

## Verification
The assertions check the word counter on every cycle. It must restart at position 1 on any flag, advance by one per word otherwise, and stay idle on flagless input. They also check that the strobe is a single-cycle pulse that never follows a flagged sample, and that the held packet changes only when a packet completes. The bench scenarios are what show the field positions are right. They sweep every command and bank value, every spare-bit pattern, restarts at each word position, idle-word rejection and back-to-back packets, and check each result against fields built arithmetically.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int WORD_W  = 10;
  localparam int WORDS   = 4;
  localparam int PKT_W   = WORD_W * WORDS;
  localparam int ID_W    = 9;
  localparam int CMD_W   = 6;
  localparam int BANK_W  = 3;
  localparam int ROW_W   = 11;
  localparam int SPA_W   = 1;
  localparam int SPB_W   = 3;
  localparam int COL_W   = 7;
  localparam int ID_LSB   = PKT_W - ID_W;
  localparam int CMD_LSB  = ID_LSB - CMD_W;
  localparam int BANK_LSB = CMD_LSB - BANK_W;
  localparam int ROW_LSB  = BANK_LSB - ROW_W;
  localparam int SPA_LSB  = ROW_LSB - SPA_W;
  localparam int SPB_LSB  = SPA_LSB - SPB_W;
  localparam int COL_LSB  = SPB_LSB - COL_W;
endpackage

// File: rtl/cmd_word_seq.sv
module cmd_word_seq #(
  parameter int WORDS = 4,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flag_i,
  output logic          cap_o,
  output logic [IW-1:0] slot_o,
  output logic          last_o
);
  logic          busy_q;
  logic [IW-1:0] cnt_q;

  assign slot_o = flag_i ? '0 : cnt_q;
  assign cap_o  = flag_i | busy_q;
  assign last_o = busy_q & ~flag_i & (cnt_q == IW'(WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (flag_i) begin
      // flag always restarts, discarding any partial packet
      busy_q <= 1'b1;
      cnt_q  <= IW'(1);
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + IW'(1);
    end
  end

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i |=> (busy_q && cnt_q == IW'(1)));

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !flag_i && cnt_q != IW'(WORDS - 1)) |=>
      (busy_q && cnt_q == $past(cnt_q) + IW'(1)));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !flag_i) |=> !busy_q);
endmodule

// File: rtl/cmd_word_store.sv
module cmd_word_store #(
  parameter int WORD_W = 10,
  parameter int WORDS  = 4,
  localparam int IW    = $clog2(WORDS),
  localparam int PKT_W = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [IW-1:0]     slot_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] ca_i,
  output logic [PKT_W-1:0]  pkt_o,
  output logic              valid_o
);
  logic [WORDS-2:0][WORD_W-1:0] slot_q;
  logic [PKT_W-1:0]             asm_w;
  logic [PKT_W-1:0]             pkt_q;
  logic                         valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
    end else if (cap_i) begin
      for (int k = 0; k < WORDS - 1; k++) begin
        if (slot_i == IW'(k)) slot_q[k] <= ca_i;
      end
    end
  end

  // earlier words to the MSBs, the live last word to the LSBs
  for (genvar k = 0; k < WORDS - 1; k++) begin : g_asm
    assign asm_w[PKT_W-1-k*WORD_W -: WORD_W] = slot_q[k];
  end
  assign asm_w[WORD_W-1:0] = ca_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last_i;
      if (last_i) pkt_q <= asm_w;
    end
  end

  assign pkt_o   = pkt_q;
  assign valid_o = valid_q;

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(pkt_q));
endmodule

// File: rtl/cmd_field_dec.sv
module cmd_field_dec
  import cmd_pkg::*;
(
  input  logic [PKT_W-1:0]  pkt_i,
  input  logic              valid_i,
  output logic [ID_W-1:0]   dev_id_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              fmt_err_o
);
  logic [SPA_W-1:0] spa_w;
  logic [SPB_W-1:0] spb_w;

  assign dev_id_o  = pkt_i[ID_LSB   +: ID_W];
  assign cmd_o     = pkt_i[CMD_LSB  +: CMD_W];
  assign bank_o    = pkt_i[BANK_LSB +: BANK_W];
  assign row_o     = pkt_i[ROW_LSB  +: ROW_W];
  assign col_o     = pkt_i[COL_LSB  +: COL_W];
  assign spa_w     = pkt_i[SPA_LSB  +: SPA_W];
  assign spb_w     = pkt_i[SPB_LSB  +: SPB_W];
  assign fmt_err_o = valid_i & ((|spa_w) | (|spb_w));
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_i,
  input  logic [WORD_W-1:0] ca_i,
  output logic              pkt_valid_o,
  output logic [PKT_W-1:0]  pkt_o,
  output logic [ID_W-1:0]   dev_id_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              fmt_err_o
);
  localparam int IW = $clog2(WORDS);

  logic          cap_w;
  logic [IW-1:0] slot_w;
  logic          last_w;

  cmd_word_seq #(.WORDS(WORDS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (flag_i),
    .cap_o  (cap_w),
    .slot_o (slot_w),
    .last_o (last_w)
  );

  cmd_word_store #(.WORD_W(WORD_W), .WORDS(WORDS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap_w),
    .slot_i  (slot_w),
    .last_i  (last_w),
    .ca_i    (ca_i),
    .pkt_o   (pkt_o),
    .valid_o (pkt_valid_o)
  );

  cmd_field_dec u_dec (
    .pkt_i     (pkt_o),
    .valid_i   (pkt_valid_o),
    .dev_id_o  (dev_id_o),
    .cmd_o     (cmd_o),
    .bank_o    (bank_o),
    .row_o     (row_o),
    .col_o     (col_o),
    .fmt_err_o (fmt_err_o)
  );

  a_r9_no_strobe_after_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> !$past(flag_i));

  a_r10_err_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> pkt_valid_o);
endmodule

// File: tb/sim_cmd_framer.sv
`timescale 1ns/1ps
module sim_cmd_framer;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        flag_i;
  logic [9:0]  ca_i;
  logic        pkt_valid_o;
  logic [39:0] pkt_o;
  logic [8:0]  dev_id_o;
  logic [5:0]  cmd_o;
  logic [2:0]  bank_o;
  logic [10:0] row_o;
  logic [6:0]  col_o;
  logic        fmt_err_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  cmd_framer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flag_i(flag_i), .ca_i(ca_i),
    .pkt_valid_o(pkt_valid_o), .pkt_o(pkt_o), .dev_id_o(dev_id_o),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .fmt_err_o(fmt_err_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [39:0] mk(input int dev, input int cmd, input int bank,
                                     input int row, input int col, input int sa, input int sb);
    longint w0, w1, w2, w3;
    w0 = (dev % 512) * 2 + ((cmd / 32) % 2);
    w1 = (cmd % 32) * 32 + (bank % 8) * 4 + ((row / 512) % 4);
    w2 = (row % 512) * 2 + (sa % 2);
    w3 = (sb % 8) * 128 + (col % 128);
    return 40'(w0 * 1073741824 + w1 * 1048576 + w2 * 1024 + w3);
  endfunction

  // drive four words, strobe must stay low until the word-4 edge
  task automatic send(input logic [39:0] p);
    for (int i = 0; i < 4; i++) begin
      flag_i = (i == 0);
      ca_i   = p[39 - 10*i -: 10];
      tick();
      if (i < 3) chk(pkt_valid_o == 1'b0, "R2 no early strobe", 64'(pkt_valid_o), 0);
    end
  endtask

  task automatic chk_pkt(input int dev, input int cmd, input int bank,
                         input int row, input int col, input int sa, input int sb);
    logic [39:0] e;
    e = mk(dev, cmd, bank, row, col, sa, sb);
    chk(pkt_valid_o == 1'b1, "R2 strobe", 64'(pkt_valid_o), 1);
    chk(pkt_o == e, "R2 packet", 64'(pkt_o), 64'(e));
    chk(dev_id_o == 9'(dev), "R3 dev_id", 64'(dev_id_o), 64'(dev));
    chk(cmd_o == 6'(cmd), "R4 cmd", 64'(cmd_o), 64'(cmd));
    chk(bank_o == 3'(bank), "R5 bank", 64'(bank_o), 64'(bank));
    chk(row_o == 11'(row), "R6 row", 64'(row_o), 64'(row));
    chk(col_o == 7'(col), "R7 col", 64'(col_o), 64'(col));
    chk(fmt_err_o == ((sa != 0) || (sb != 0)), "R10 fmt_err",
        64'(fmt_err_o), 64'((sa != 0) || (sb != 0)));
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [39:0] held;
    rst_ni = 1'b0;
    flag_i = 1'b0;
    ca_i   = '0;
    tick(); tick();
    chk(pkt_valid_o == 0, "R1 valid in reset", 64'(pkt_valid_o), 0);
    chk(fmt_err_o == 0, "R1 fmt_err in reset", 64'(fmt_err_o), 0);
    chk(pkt_o == 0, "R1 packet in reset", 64'(pkt_o), 0);
    rst_ni = 1'b1;
    tick();
    chk(pkt_valid_o == 0, "R1 valid after reset", 64'(pkt_valid_o), 0);

    // R8: flagless words while idle
    for (int i = 0; i < 8; i++) begin
      flag_i = 1'b0;
      ca_i   = 10'(i * 131 + 7);
      tick();
      chk(pkt_valid_o == 0, "R8 idle strobe", 64'(pkt_valid_o), 0);
      chk(pkt_o == 0, "R8 idle packet", 64'(pkt_o), 0);
    end

    // extremes
    send(mk(511, 63, 7, 2047, 127, 0, 0));
    chk_pkt(511, 63, 7, 2047, 127, 0, 0);
    send(mk(0, 0, 0, 0, 0, 0, 0));
    chk_pkt(0, 0, 0, 0, 0, 0, 0);

    // R12 back-to-back sweep over every command and bank
    for (int c = 0; c < 64; c++) begin
      for (int b = 0; b < 8; b++) begin
        send(mk((c*37 + b*11) % 512, c, b, (c*29 + b*251) % 2048, (c + b*13) % 128, 0, 0));
        chk_pkt((c*37 + b*11) % 512, c, b, (c*29 + b*251) % 2048, (c + b*13) % 128, 0, 0);
      end
    end

    // R11: strobe drops, data held
    held   = pkt_o;
    flag_i = 1'b0;
    ca_i   = 10'h3ff;
    tick();
    chk(pkt_valid_o == 0, "R11 strobe one cycle", 64'(pkt_valid_o), 0);
    chk(pkt_o == held, "R11 packet held", 64'(pkt_o), 64'(held));
    chk(fmt_err_o == 0, "R10 no err outside strobe", 64'(fmt_err_o), 0);
    tick();
    chk(pkt_o == held, "R11 packet held 2", 64'(pkt_o), 64'(held));

    // R10: every spare pattern
    for (int s = 0; s < 16; s++) begin
      send(mk(s*31, 63 - s, s % 8, s*127, s*7, s / 8, s % 8));
      chk_pkt(s*31, 63 - s, s % 8, s*127, s*7, s / 8, s % 8);
    end
    flag_i = 1'b0;
    tick();
    chk(fmt_err_o == 0, "R10 err cleared", 64'(fmt_err_o), 0);

    // R9: restart at each word position 2..4
    for (int n = 1; n < 4; n++) begin
      logic [39:0] junk;
      junk = mk(300, 50, 5, 1500, 99, 1, 7);
      for (int i = 0; i < n; i++) begin
        flag_i = (i == 0);
        ca_i   = junk[39 - 10*i -: 10];
        tick();
        chk(pkt_valid_o == 0, "R9 partial no strobe", 64'(pkt_valid_o), 0);
      end
      send(mk(100 + n, 20 + n, n, 700 + n, 40 + n, 0, 0));
      chk_pkt(100 + n, 20 + n, n, 700 + n, 40 + n, 0, 0);
    end

    flag_i = 1'b0;
    tick();
    chk(pkt_valid_o == 0, "R11 final strobe low", 64'(pkt_valid_o), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule